// File: doc/BRIEF.md
# Paged RAM address generator

This block keeps the flag register of a small 8-bit processor and uses the page-mode field of that register to form the physical address of every data RAM access. The data RAM is 2K bytes, split into eight 256-byte pages. Each access gives an 8-bit operand offset and says whether the operand is direct or indexed. The mode field then picks which of three page pointers supplies the upper address bits: current, index or stack. For some modes it picks the fixed page 0 instead.

Software changes the flag register only through masked AND, OR and XOR operations. These are applied on a clock edge. Entry into an interrupt service routine clears the whole register, so the paging falls back to page 0 for both kinds of access. The register also holds a register-space select, a carry flag, a zero flag and a global interrupt enable.

The address path is combinational. A mode written on one edge therefore governs the accesses of the following cycle.

Top module: `pag_addr_gen`

## Requirements
- R1: After reset, all eight bits of `flags` are 0.
- R2: With `flag_op` = 01 (AND) and no interrupt entry, `flags` becomes the old value ANDed with `flag_mask` after the next rising edge.
- R3: With `flag_op` = 10 (OR) and no interrupt entry, `flags` becomes the old value ORed with `flag_mask` after the next rising edge.
- R4: With `flag_op` = 11 (XOR) and no interrupt entry, `flags` becomes the old value XORed with `flag_mask` after the next rising edge.
- R5: Bits 5 and 3 of `flags` are reserved and always read 0. The other fields are: bits 7:6 page mode, bit 4 extended register space, bit 2 carry, bit 1 zero, bit 0 global interrupt enable.
- R6: `irq_entry` high clears `flags` to 0 on the next edge. It takes priority over any flag operation in the same cycle.
- R7: In page mode 00, `ram_addr[10:8]` is 0 for both direct and indexed accesses (`acc_indexed` = 0 or 1).
- R8: In page mode 01, direct accesses use page 0 and indexed accesses use `stk_page`.
- R9: In page mode 10, direct accesses use `cur_page` and indexed accesses use `idx_page`.
- R10: In page mode 11, direct accesses use `cur_page` and indexed accesses use `stk_page`.
- R11: `ram_addr` = {page, `offset`} and follows its inputs in the same cycle. A mode written on an edge applies from the next cycle onward.
- R12: With `flag_op` = 00 and no interrupt entry, `flags` holds its value whatever `flag_mask` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| flag_op | input | 2 | Flag operation: 00 none, 01 AND, 10 OR, 11 XOR |
| flag_mask | input | 8 | Immediate mask for the flag operation |
| irq_entry | input | 1 | Interrupt service entry, clears the flags |
| offset | input | 8 | Operand offset within a page |
| acc_indexed | input | 1 | 1 = indexed access, 0 = direct access |
| cur_page | input | 3 | Current page pointer |
| idx_page | input | 3 | Index page pointer |
| stk_page | input | 3 | Stack page pointer |
| flags | output | 8 | Flag register contents |
| ram_addr | output | 11 | Physical RAM address |

## Verification
Two events can fall in the same cycle: a masked flag operation and an interrupt entry. The bench provokes this by driving an OR with an all-ones mask together with `irq_entry` high. It judges the outcome by checking that `flags` reads 0 afterward and that the address falls back to page 0. A second overlap is a mode write together with an access. Here the bench checks that `ram_addr` still uses the old mode before the edge and uses the new one after it.

// File: rtl/pag_pkg.sv
package pag_pkg;

    localparam int FLAG_W = 8;

    // bit positions of the flag register
    localparam int F_MODE_HI = 7;
    localparam int F_MODE_LO = 6;
    localparam int F_RSV_HI  = 5;
    localparam int F_EXT     = 4;
    localparam int F_RSV_LO  = 3;
    localparam int F_CARRY   = 2;
    localparam int F_ZERO    = 1;
    localparam int F_GIE     = 0;

    // mask of bits that may hold a 1
    localparam logic [FLAG_W-1:0] KEEP_MASK = 8'b1101_0111;

    typedef enum logic [1:0] {
        FOP_NONE = 2'b00,
        FOP_AND  = 2'b01,
        FOP_OR   = 2'b10,
        FOP_XOR  = 2'b11
    } flag_op_e;

    typedef enum logic [1:0] {
        PM_ZERO   = 2'b00,
        PM_STACK  = 2'b01,
        PM_CURIDX = 2'b10,
        PM_CURSTK = 2'b11
    } page_mode_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } flag_state_t;

endpackage

// File: rtl/pag_flag_reg.sv
module pag_flag_reg
    import pag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic [FLAG_W-1:0] mask_i,
    input  logic              clear_i,
    output logic [FLAG_W-1:0] flags_o
);

    flag_state_t st_d, st_q;
    flag_op_e    op;
    logic [FLAG_W-1:0] result;

    always_comb begin
        op     = flag_op_e'(op_i);
        st_d   = st_q;
        result = st_q.flags;
        unique case (op)
            FOP_AND:  result = st_q.flags & mask_i;
            FOP_OR:   result = st_q.flags | mask_i;
            FOP_XOR:  result = st_q.flags ^ mask_i;
            default:  result = st_q.flags;
        endcase
        if (clear_i) begin
            st_d.flags = '0;
        end else begin
            st_d.flags = result & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/pag_page_sel.sv
module pag_page_sel
    import pag_pkg::*;
#(
    parameter int PAGE_W = 3
) (
    input  logic [1:0]        mode_i,
    input  logic              indexed_i,
    input  logic [PAGE_W-1:0] cur_i,
    input  logic [PAGE_W-1:0] idx_i,
    input  logic [PAGE_W-1:0] stk_i,
    output logic [PAGE_W-1:0] page_o
);

    page_mode_e        mode;
    logic [PAGE_W-1:0] dir_page;
    logic [PAGE_W-1:0] ind_page;

    always_comb begin
        mode     = page_mode_e'(mode_i);
        dir_page = '0;
        ind_page = '0;
        unique case (mode)
            PM_ZERO: begin
                dir_page = '0;
                ind_page = '0;
            end
            PM_STACK: begin
                dir_page = '0;
                ind_page = stk_i;
            end
            PM_CURIDX: begin
                dir_page = cur_i;
                ind_page = idx_i;
            end
            default: begin
                dir_page = cur_i;
                ind_page = stk_i;
            end
        endcase
        page_o = indexed_i ? ind_page : dir_page;
    end

endmodule

// File: rtl/pag_addr_gen.sv
module pag_addr_gen
    import pag_pkg::*;
#(
    parameter int OFS_W  = 8,
    parameter int PAGE_W = 3,
    localparam int ADDR_W = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        flag_op,
    input  logic [7:0]        flag_mask,
    input  logic              irq_entry,
    input  logic [OFS_W-1:0]  offset,
    input  logic              acc_indexed,
    input  logic [PAGE_W-1:0] cur_page,
    input  logic [PAGE_W-1:0] idx_page,
    input  logic [PAGE_W-1:0] stk_page,
    output logic [7:0]        flags,
    output logic [ADDR_W-1:0] ram_addr
);

    logic [FLAG_W-1:0] flags_q;
    logic [PAGE_W-1:0] page;

    pag_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (flag_op),
        .mask_i  (flag_mask),
        .clear_i (irq_entry),
        .flags_o (flags_q)
    );

    pag_page_sel #(.PAGE_W(PAGE_W)) u_sel (
        .mode_i    (flags_q[F_MODE_HI:F_MODE_LO]),
        .indexed_i (acc_indexed),
        .cur_i     (cur_page),
        .idx_i     (idx_page),
        .stk_i     (stk_page),
        .page_o    (page)
    );

    assign flags    = flags_q;
    assign ram_addr = {page, offset};

endmodule

// File: rtl/pag_addr_gen_chk.sv
module pag_addr_gen_chk #(
    parameter int OFS_W  = 8,
    parameter int PAGE_W = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [1:0]              flag_op,
    input logic [7:0]              flag_mask,
    input logic                    irq_entry,
    input logic [OFS_W-1:0]        offset,
    input logic                    acc_indexed,
    input logic [PAGE_W-1:0]       cur_page,
    input logic [PAGE_W-1:0]       idx_page,
    input logic [PAGE_W-1:0]       stk_page,
    input logic [7:0]              flags,
    input logic [PAGE_W+OFS_W-1:0] ram_addr
);

    assert_irq_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_entry |=> (flags == 8'h00));

    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[5] == 1'b0) && (flags[3] == 1'b0));

    assert_and_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_entry && flag_op == 2'b01) |=> (flags == ($past(flags) & $past(flag_mask) & 8'hD7)));

    assert_or_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_entry && flag_op == 2'b10) |=> (flags == (($past(flags) | $past(flag_mask)) & 8'hD7)));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_entry && flag_op == 2'b00) |=> $stable(flags));

    assert_offset_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ram_addr[OFS_W-1:0] == offset);

    assert_mode0_page0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[7:6] == 2'b00) |-> (ram_addr[PAGE_W+OFS_W-1:OFS_W] == '0));

    assert_mode2_idx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[7:6] == 2'b10 && acc_indexed) |-> (ram_addr[PAGE_W+OFS_W-1:OFS_W] == idx_page));

endmodule

bind pag_addr_gen pag_addr_gen_chk #(.OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_op     (flag_op),
    .flag_mask   (flag_mask),
    .irq_entry   (irq_entry),
    .offset      (offset),
    .acc_indexed (acc_indexed),
    .cur_page    (cur_page),
    .idx_page    (idx_page),
    .stk_page    (stk_page),
    .flags       (flags),
    .ram_addr    (ram_addr)
);

// File: tb/pag_addr_gen_tb.sv
module pag_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  flag_op = 2'b00;
    logic [7:0]  flag_mask = 8'h00;
    logic        irq_entry = 1'b0;
    logic [7:0]  offset = 8'h00;
    logic        acc_indexed = 1'b0;
    logic [2:0]  cur_page = 3'd5;
    logic [2:0]  idx_page = 3'd2;
    logic [2:0]  stk_page = 3'd7;
    logic [7:0]  flags;
    logic [10:0] ram_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pag_addr_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag_op     (flag_op),
        .flag_mask   (flag_mask),
        .irq_entry   (irq_entry),
        .offset      (offset),
        .acc_indexed (acc_indexed),
        .cur_page    (cur_page),
        .idx_page    (idx_page),
        .stk_page    (stk_page),
        .flags       (flags),
        .ram_addr    (ram_addr)
    );

    // {mode[1:0], indexed, offset[7:0], expected addr[10:0]}, cur=5 idx=2 stk=7
    localparam logic [21:0] VEC [8] = '{
        {2'b00, 1'b0, 8'h12, 11'h012},
        {2'b00, 1'b1, 8'h34, 11'h034},
        {2'b01, 1'b0, 8'h56, 11'h056},
        {2'b01, 1'b1, 8'h78, 11'h778},
        {2'b10, 1'b0, 8'h9A, 11'h59A},
        {2'b10, 1'b1, 8'hBC, 11'h2BC},
        {2'b11, 1'b0, 8'hDE, 11'h5DE},
        {2'b11, 1'b1, 8'hFF, 11'h7FF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [7:0] mask, input logic irq);
        @(negedge clk);
        flag_op   = op;
        flag_mask = mask;
        irq_entry = irq;
        @(negedge clk);
        flag_op   = 2'b00;
        irq_entry = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset flags", flags, 8'h00);

        // vector table: R7 R8 R9 R10 R11
        foreach (VEC[i]) begin
            do_op(2'b01, 8'h3F, 1'b0);
            do_op(2'b10, {VEC[i][21:20], 6'b0}, 1'b0);
            offset      = VEC[i][18:11];
            acc_indexed = VEC[i][19];
            #1;
            case (VEC[i][21:20])
                2'b00:   check("R7 mode00 addr", ram_addr, VEC[i][10:0]);
                2'b01:   check("R8 mode01 addr", ram_addr, VEC[i][10:0]);
                2'b10:   check("R9 mode10 addr", ram_addr, VEC[i][10:0]);
                default: check("R10 mode11 addr", ram_addr, VEC[i][10:0]);
            endcase
        end

        // clear, then flag operations
        do_op(2'b00, 8'h00, 1'b1);
        check("R6 irq alone clears", flags, 8'h00);
        do_op(2'b10, 8'hFF, 1'b0);
        check("R3 OR all ones, R5 reserved low", flags, 8'hD7);
        do_op(2'b01, 8'h55, 1'b0);
        check("R2 AND 55", flags, 8'h55);
        do_op(2'b11, 8'hFF, 1'b0);
        check("R4 XOR ff", flags, 8'h82);
        do_op(2'b00, 8'hFF, 1'b0);
        check("R12 no-op holds", flags, 8'h82);

        // same-cycle irq and OR
        do_op(2'b10, 8'hFF, 1'b1);
        check("R6 irq beats OR", flags, 8'h00);
        acc_indexed = 1'b0;
        offset      = 8'h44;
        #1;
        check("R6 addr back to page 0", ram_addr, 11'h044);

        // mode timing: write mode 11 while accessing
        @(negedge clk);
        flag_op   = 2'b10;
        flag_mask = 8'hC0;
        #1;
        check("R11 old mode before edge", ram_addr, 11'h044);
        @(posedge clk);
        #1;
        flag_op = 2'b00;
        check("R11 new mode after edge", ram_addr, 11'h544);
        acc_indexed = 1'b1;
        #1;
        check("R10 indexed after write", ram_addr, 11'h744);

        // reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", flags, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule